// File: doc/BRIEF.md
# Smartcard Character Transceiver with Parity-Error Signalling

This block moves bytes over a single shared open-drain wire to and from an asynchronous smartcard. Every character on the wire is a low start bit, eight data bits sent least significant bit first, and an even parity bit, followed by a released stop and guard period one and a half bits long. The block never drives the wire high: its one line output means "pull low", and the board wires it together with the far end's driver.

In character mode a receiver that sees a bad parity bit pulls the wire low for one bit time, starting half a bit into the stop period. The transmitter reads the wire in that window and reports whether the far end refused the byte. In block mode no such pull is made or checked, but the receiver still flags the parity error. Bytes enter and leave on valid/ready handshakes. The bit timing comes from a programmable half-bit divider, counted in clock cycles. While the block is sending, its receiver ignores the wire.

Top module: `sc_char_xcvr`

## Requirements
- R1: A transmitted character pulls the line low for a start bit, then shows data bits 0 to 7 in that order, then even parity (XOR of the eight data bits). A line bit of value 0 is a pull, and each bit lasts 2*half_div_i cycles.
- R2: After a byte is accepted (tx_valid_i and tx_ready_o high on a rising edge), the line stays released for at least half_div_i cycles before the start bit.
- R3: After the parity bit the transmitter leaves the line released for three half-bit periods. Only then does it pulse tx_done_o for one cycle, with tx_ready_o high again.
- R4: In character mode (block_mode_i = 0) the transmitter reads the line one bit time into the stop period. If the line is low there, tx_nack_o is 1 when tx_done_o pulses, and 0 otherwise. In block mode tx_nack_o is always 0.
- R5: The receiver finds the middle of the start bit and samples each later bit one bit time apart. It presents the byte on rx_data_o with rx_valid_o, and holds rx_valid_o until rx_ready_i is seen high.
- R6: rx_perr_o, valid with the byte, is 1 when the received parity bit differs from the XOR of the received data bits.
- R7: In character mode, when there is a parity error, the receiver pulls the line low for one bit time, starting half a bit time into the stop period, and then releases it. When there is no error, the line stays released.
- R8: In block mode a parity error sets rx_perr_o but the line is never pulled.
- R9: A low pulse that has ended by the middle of the start bit is rejected, and no byte is delivered.
- R10: While the transmitter is busy the receiver ignores the line, so the block's own characters, and any pull seen in its own guard period, produce no rx_valid_o.
- R11: If a new byte completes while rx_valid_o is still pending and not taken, the new byte replaces the old one and rx_overrun_o pulses for one cycle.
- R12: After reset the line is released, tx_ready_o is 1, rx_valid_o is 0 and tx_nack_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_div_i | input | DIV_W | Half-bit period in clock cycles (2 or more) |
| block_mode_i | input | 1 | 0 = character mode with error signalling, 1 = block mode |
| tx_data_i | input | 8 | Byte to send |
| tx_valid_i | input | 1 | Transmit byte offered |
| tx_ready_o | output | 1 | Transmitter idle and able to take a byte |
| tx_done_o | output | 1 | One-cycle pulse at the end of a character's guard period |
| tx_nack_o | output | 1 | Far end signalled a parity error for the last character sent |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Received byte pending |
| rx_ready_i | input | 1 | Consumer takes the pending byte |
| rx_perr_o | output | 1 | Parity error on the pending byte |
| rx_overrun_o | output | 1 | One-cycle pulse when a pending byte was replaced |
| line_i | input | 1 | Level of the shared wire |
| line_low_o | output | 1 | 1 = pull the shared wire low, 0 = release it |

## Verification
The bench acts as the far end on a wired-AND model of the line. It sends every byte value from the block, checks each bit at its middle, and pulls the line during the stop period for a byte-dependent half of them, so both NACK outcomes appear on many different data patterns. It then sends every byte value into the block, once with correct parity and once with inverted parity. This separates data, parity-flag and pull-low faults across all bit positions, and the block-mode runs separate the two modes. A short glitch, an unconsumed byte followed by a second one, and a count of received bytes across the whole transmit sweep separate start validation, overrun handling and receive masking.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int DATA_BITS  = 8;
  localparam int FRAME_BITS = DATA_BITS + 2;          // start + data + parity
  localparam int HC_W       = 5;
  localparam logic [HC_W-1:0] TX_LAST_HALF = HC_W'(2 * FRAME_BITS - 1);
  localparam logic [HC_W-1:0] RX_PAR_HALF  = HC_W'(2 * DATA_BITS + 1);

  typedef enum logic [1:0] {TX_IDLE, TX_LEAD, TX_BITS, TX_GUARD} tx_st_t;
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP, RX_PULL} rx_st_t;

  function automatic logic even_par(input logic [DATA_BITS-1:0] d);
    return ^d;
  endfunction
endpackage

// File: rtl/sc_line_sync.sv
module sc_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sc_half_timer.sv
module sc_half_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_cyc,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == half_cyc - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sc_tx.sv
module sc_tx
  import sc_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DIV_W-1:0]     half_cyc,
  input  logic                 block_mode,
  input  logic [DATA_BITS-1:0] tx_data,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  input  logic                 line_in,
  output logic                 tx_low,
  output logic                 busy,
  output logic                 done,
  output logic                 nack
);
  tx_st_t                st;
  logic [HC_W-1:0]       hcnt;
  logic [FRAME_BITS-1:0] frame;
  logic                  nack_q;
  logic                  tick;

  sc_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .run      (st != TX_IDLE),
    .half_cyc (half_cyc),
    .tick     (tick)
  );

  assign tx_ready = (st == TX_IDLE);
  assign busy     = (st != TX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= TX_IDLE;
      hcnt   <= '0;
      frame  <= '1;
      tx_low <= 1'b0;
      done   <= 1'b0;
      nack   <= 1'b0;
      nack_q <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        TX_IDLE: begin
          if (tx_valid) begin
            frame  <= {even_par(tx_data), tx_data, 1'b0};
            nack_q <= 1'b0;
            st     <= TX_LEAD;
          end
        end
        TX_LEAD: begin
          if (tick) begin
            st     <= TX_BITS;
            hcnt   <= '0;
            tx_low <= ~frame[0];
          end
        end
        TX_BITS: begin
          if (tick) begin
            if (hcnt == TX_LAST_HALF) begin
              st     <= TX_GUARD;
              hcnt   <= '0;
              tx_low <= 1'b0;
            end else begin
              hcnt <= hcnt + 1'b1;
              if (hcnt[0]) begin
                frame  <= {1'b1, frame[FRAME_BITS-1:1]};
                tx_low <= ~frame[1];
              end
            end
          end
        end
        TX_GUARD: begin
          if (tick) begin
            hcnt <= hcnt + 1'b1;
            if (hcnt == HC_W'(1) && !block_mode && !line_in) nack_q <= 1'b1;
            if (hcnt == HC_W'(2)) begin
              st   <= TX_IDLE;
              done <= 1'b1;
              nack <= nack_q;
            end
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  AST_TX_LEAD_QUIET: assert property (@(posedge clk) disable iff (rst)
    (tx_ready && tx_valid) |=> !tx_low); // R2
  AST_TX_GUARD_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (st == TX_GUARD) |-> !tx_low); // R3
  AST_TX_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> $rose(tx_ready)); // R3
endmodule

// File: rtl/sc_rx.sv
module sc_rx
  import sc_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DIV_W-1:0]     half_cyc,
  input  logic                 block_mode,
  input  logic                 line_in,
  input  logic                 ignore,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  input  logic                 rx_ready,
  output logic                 rx_perr,
  output logic                 rx_overrun,
  output logic                 rx_low
);
  rx_st_t                st;
  logic [HC_W-1:0]       hcnt;
  logic [DATA_BITS-1:0]  sreg;
  logic                  line_prev;
  logic                  perr_q;
  logic                  tick;
  logic                  perr_now;

  sc_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .run      (st != RX_IDLE),
    .half_cyc (half_cyc),
    .tick     (tick)
  );

  assign perr_now = even_par(sreg) ^ line_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= RX_IDLE;
      hcnt       <= '0;
      sreg       <= '0;
      line_prev  <= 1'b1;
      perr_q     <= 1'b0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      rx_perr    <= 1'b0;
      rx_overrun <= 1'b0;
      rx_low     <= 1'b0;
    end else begin
      line_prev  <= line_in;
      rx_overrun <= 1'b0;
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      unique case (st)
        RX_IDLE: begin
          if (!ignore && line_prev && !line_in) st <= RX_START;
        end
        RX_START: begin
          if (tick) begin
            hcnt <= '0;
            st   <= line_in ? RX_IDLE : RX_BITS;
          end
        end
        RX_BITS: begin
          if (tick) begin
            hcnt <= hcnt + 1'b1;
            if (hcnt == RX_PAR_HALF) begin
              rx_data    <= sreg;
              rx_perr    <= perr_now;
              perr_q     <= perr_now;
              rx_overrun <= rx_valid && !rx_ready;
              rx_valid   <= 1'b1;
              hcnt       <= '0;
              st         <= RX_STOP;
            end else if (hcnt[0]) begin
              sreg <= {line_in, sreg[DATA_BITS-1:1]};
            end
          end
        end
        RX_STOP: begin
          if (tick) begin
            hcnt <= hcnt + 1'b1;
            if (hcnt == HC_W'(1)) begin
              hcnt <= '0;
              if (perr_q && !block_mode) begin
                rx_low <= 1'b1;
                st     <= RX_PULL;
              end else begin
                st <= RX_IDLE;
              end
            end
          end
        end
        RX_PULL: begin
          if (tick) begin
            hcnt <= hcnt + 1'b1;
            if (hcnt == HC_W'(1)) begin
              rx_low <= 1'b0;
              st     <= RX_IDLE;
            end
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  AST_RX_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> rx_valid); // R5
  AST_RX_PULL_ON_ERROR: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_low) |-> rx_perr); // R7
  AST_RX_NO_PULL_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (st == RX_STOP && tick && block_mode) |=> !rx_low); // R8
  AST_RX_IGNORE_TX: assert property (@(posedge clk) disable iff (rst)
    (st == RX_IDLE && ignore) |=> (st == RX_IDLE)); // R10
endmodule

// File: rtl/sc_char_xcvr.sv
module sc_char_xcvr
  import sc_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DIV_W-1:0]     half_div_i,
  input  logic                 block_mode_i,
  input  logic [DATA_BITS-1:0] tx_data_i,
  input  logic                 tx_valid_i,
  output logic                 tx_ready_o,
  output logic                 tx_done_o,
  output logic                 tx_nack_o,
  output logic [DATA_BITS-1:0] rx_data_o,
  output logic                 rx_valid_o,
  input  logic                 rx_ready_i,
  output logic                 rx_perr_o,
  output logic                 rx_overrun_o,
  input  logic                 line_i,
  output logic                 line_low_o
);
  logic line_s;
  logic tx_low;
  logic rx_low;
  logic tx_busy;

  sc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (line_i),
    .q   (line_s)
  );

  sc_tx #(.DIV_W(DIV_W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .half_cyc   (half_div_i),
    .block_mode (block_mode_i),
    .tx_data    (tx_data_i),
    .tx_valid   (tx_valid_i),
    .tx_ready   (tx_ready_o),
    .line_in    (line_s),
    .tx_low     (tx_low),
    .busy       (tx_busy),
    .done       (tx_done_o),
    .nack       (tx_nack_o)
  );

  sc_rx #(.DIV_W(DIV_W)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .half_cyc   (half_div_i),
    .block_mode (block_mode_i),
    .line_in    (line_s),
    .ignore     (tx_busy),
    .rx_data    (rx_data_o),
    .rx_valid   (rx_valid_o),
    .rx_ready   (rx_ready_i),
    .rx_perr    (rx_perr_o),
    .rx_overrun (rx_overrun_o),
    .rx_low     (rx_low)
  );

  always_ff @(posedge clk) begin
    if (rst) line_low_o <= 1'b0;
    else     line_low_o <= tx_low | rx_low;
  end

  AST_RESET_RELEASED: assert property (@(posedge clk)
    $past(rst) |-> (!line_low_o && !rx_valid_o)); // R12
endmodule

// File: tb/sc_char_xcvr_tb_top.sv
module sc_char_xcvr_tb_top;
  localparam int H = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       block_mode = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready, tx_done, tx_nack;
  logic [7:0] rx_data;
  logic       rx_valid, rx_perr, rx_overrun;
  logic       rx_ready = 1'b0;
  logic       bench_low = 1'b0;
  logic       line_low;
  logic       line_w;

  int nvec = 0;
  int nbad = 0;
  int done_cnt = 0;
  int ovr_cnt = 0;
  int rxv_rise = 0;
  logic last_nack = 1'b0;
  logic rxv_q = 1'b0;
  logic finished = 1'b0;

  always #10 clk = ~clk;

  assign line_w = ~(line_low | bench_low);

  sc_char_xcvr dut_i (
    .clk          (clk),
    .rst          (rst),
    .half_div_i   (16'(H)),
    .block_mode_i (block_mode),
    .tx_data_i    (tx_data),
    .tx_valid_i   (tx_valid),
    .tx_ready_o   (tx_ready),
    .tx_done_o    (tx_done),
    .tx_nack_o    (tx_nack),
    .rx_data_o    (rx_data),
    .rx_valid_o   (rx_valid),
    .rx_ready_i   (rx_ready),
    .rx_perr_o    (rx_perr),
    .rx_overrun_o (rx_overrun),
    .line_i       (line_w),
    .line_low_o   (line_low)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (tx_done) begin
        done_cnt++;
        last_nack = tx_nack;
      end
      if (rx_overrun) ovr_cnt++;
      if (rx_valid && !rxv_q) rxv_rise++;
      rxv_q = rx_valid;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tx_frame(input logic [7:0] b, input logic pull, input logic exp_nack);
    int lead;
    int dc;
    logic [9:0] bits;
    bits = {^b, b, 1'b0};
    dc = done_cnt;
    @(negedge clk);
    tx_data  = b;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    lead = 0;
    while (!line_low && lead < 200) begin
      @(negedge clk);
      lead++;
    end
    chk("R2 lead release", 32'(lead >= H), 32'd1);
    repeat (H) @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      chk("R1 line bit", {31'd0, line_low}, {31'd0, ~bits[k]});
      if (k < 9) repeat (2 * H) @(negedge clk);
    end
    repeat (2 * H) @(negedge clk);
    chk("R3 stop released", {31'd0, line_low}, 32'd0);
    bench_low = pull;
    repeat (2 * H) @(negedge clk);
    bench_low = 1'b0;
    repeat (2) @(negedge clk);
    chk("R3 done pulse", 32'(done_cnt - dc), 32'd1);
    chk("R3 ready again", {31'd0, tx_ready}, 32'd1);
    chk("R4 nack", {31'd0, last_nack}, {31'd0, exp_nack});
  endtask

  task automatic rx_frame(input logic [7:0] b, input logic bad, input logic exp_pull,
                          input logic consume);
    logic [9:0] bits;
    bits = {(^b) ^ bad, b, 1'b0};
    @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      bench_low = ~bits[k];
      repeat (2 * H) @(negedge clk);
    end
    bench_low = 1'b0;
    repeat (H) @(negedge clk);
    chk("R5 valid", {31'd0, rx_valid}, 32'd1);
    chk("R5 data", {24'd0, rx_data}, {24'd0, b});
    chk("R6 parity flag", {31'd0, rx_perr}, {31'd0, bad});
    repeat (H) @(negedge clk);
    chk("R7 R8 pull in stop", {31'd0, line_low}, {31'd0, exp_pull});
    repeat (2 * H) @(negedge clk);
    chk("R7 released after pull", {31'd0, line_low}, 32'd0);
    if (consume) begin
      rx_ready = 1'b1;
      @(negedge clk);
      rx_ready = 1'b0;
      chk("R5 taken", {31'd0, rx_valid}, 32'd0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nbad++;
      nvec++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    int rr;
    int oc;
    repeat (4) @(negedge clk);
    chk("R12 line released", {31'd0, line_low}, 32'd0);
    chk("R12 tx ready", {31'd0, tx_ready}, 32'd1);
    chk("R12 rx empty", {31'd0, rx_valid}, 32'd0);
    chk("R12 nack clear", {31'd0, tx_nack}, 32'd0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // Transmit sweep, character mode; far end refuses a byte-dependent half
    rr = rxv_rise;
    for (int i = 0; i < 256; i++) begin
      logic p;
      p = i[0] ^ i[7] ^ i[3];
      tx_frame(8'(i), p, p);
    end
    chk("R10 no self receive", 32'(rxv_rise - rr), 32'd0);

    // Block mode transmit: pull is not reported
    block_mode = 1'b1;
    tx_frame(8'hA5, 1'b1, 1'b0);
    tx_frame(8'h3C, 1'b0, 1'b0);
    block_mode = 1'b0;

    // Receive sweep, good and bad parity, character mode
    for (int i = 0; i < 256; i++) rx_frame(8'(i), 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 256; i++) rx_frame(8'(i), 1'b1, 1'b1, 1'b1);

    // Block mode receive with bad parity: flag only
    block_mode = 1'b1;
    rx_frame(8'h96, 1'b1, 1'b0, 1'b1);
    rx_frame(8'h0F, 1'b0, 1'b0, 1'b1);
    block_mode = 1'b0;

    // Start glitch rejected
    rr = rxv_rise;
    @(negedge clk);
    bench_low = 1'b1;
    repeat (2) @(negedge clk);
    bench_low = 1'b0;
    repeat (30 * H) @(negedge clk);
    chk("R9 glitch rejected", 32'(rxv_rise - rr), 32'd0);
    chk("R9 no valid", {31'd0, rx_valid}, 32'd0);

    // Overrun: second byte replaces an untaken first byte
    oc = ovr_cnt;
    rx_frame(8'h11, 1'b0, 1'b0, 1'b0);
    chk("R11 no overrun yet", 32'(ovr_cnt - oc), 32'd0);
    rx_frame(8'hE7, 1'b0, 1'b0, 1'b1);
    chk("R11 overrun pulse", 32'(ovr_cnt - oc), 32'd1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule